// File: doc/BRIEF.md
# DMA Command Front End

This block is the command front end of a small co-processor's DMA unit. Software writes a set of write-only parameter channels through one narrow write port. The channels are a local-store address, the high and low words of an effective address, a transfer size and a tag group number. Each value is range-checked as it arrives. A value out of range is dropped, leaves the staged register as it was, and sets a sticky error flag.

A write to the command channel decodes an 8-bit command code against the staged size. A legal code raises a request carrying the staged arguments and a class: single transfer, list transfer, atomic line operation or ordering barrier. The request is held until the downstream engine accepts it. Any accepted command write clears the staged arguments to zero. While a request waits for acceptance, the command channel stalls and a command write is dropped with no effect. The block also holds a tag-mask register and a tag-status register; the status register is loaded from the mask on request.

Top module: `dma_cmd_front`

## Requirements
- R1: After reset, req_valid, cmd_stall and err_flag are 0, tag_mask and tag_stat are 0, and every staged argument is 0.
- R2: A write to channel 0 (local-store address) is taken when the value is below 0x40000. Otherwise it is rejected: the staged address is unchanged and err_flag is set.
- R3: A write to channel 3 (size) is taken when the value is at most 16384. A larger value is rejected in the same way.
- R4: A write to channel 4 (tag) is taken when the value is below 32. A larger value is rejected in the same way.
- R5: Channels 1 and 2 take any value. req_ea is {word from channel 1, word from channel 2}.
- R6: A command write on channel 5, taken when cmd_stall is 0, with a legal code in wr_data[7:0] raises req_valid on the next cycle. The request carries that code and the staged arguments. Any taken command write, legal or not, returns all staged arguments to 0.
- R7: Codes with upper nibble 2 (put), 3 (reversed put) or 4 (get), bit 3 clear and bits [1:0] not 3 are transfers. Bits [1:0] give 1 = barrier and 2 = fence. req_class is 0 (single) when bit 2 is clear and 1 (list) when bit 2 is set.
- R8: Codes 0x80, 0x84 and 0x88 are atomic line operations (req_class 2). They are legal only when the staged size is exactly 128.
- R9: Codes 0xC0, 0xC8 and 0xCC are ordering barriers (req_class 3). Every other code is illegal. An illegal command raises no request and sets err_flag.
- R10: While req_valid is 1 and req_ready is 0, the request and its fields hold steady and cmd_stall is 1. A command write during the stall is dropped and leaves the staged arguments unchanged.
- R11: err_flag is sticky. err_clr clears it, but a new error in the same cycle wins.
- R12: A write to channel 6 loads tag_mask. A write to channel 7 copies tag_mask into tag_stat. No other write changes tag_stat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Channel write strobe |
| wr_ch | input | 3 | Channel number 0..7 |
| wr_data | input | 32 | Channel write value |
| cmd_stall | output | 1 | Command channel busy; a command write is dropped |
| err_clr | input | 1 | Clear the sticky error flag |
| err_flag | output | 1 | Sticky error flag |
| tag_mask | output | 32 | Tag-mask register |
| tag_stat | output | 32 | Tag-status register |
| req_valid | output | 1 | Command request valid |
| req_ready | input | 1 | Downstream engine accepts the request |
| req_class | output | 2 | 0 single, 1 list, 2 atomic, 3 barrier |
| req_code | output | 8 | Command code |
| req_lsa | output | 18 | Local-store address |
| req_ea | output | 64 | Effective address |
| req_size | output | 15 | Transfer size in bytes |
| req_tag | output | 5 | Tag group |

## Verification
The assertions check the following on every cycle:
- a rejected address, size or tag leaves its staged register unchanged and sets the error flag;
- a taken command write zeroes the staged arguments;
- a stalled request holds steady;
- an atomic request always carries size 128;
- a barrier request carries only a barrier code;
- the error flag stays set until cleared;
- a tag update copies the mask.

Only the bench scenarios can show the rest:
- the full mapping from codes to classes and legality;
- that the 64-bit address is assembled from the high and low words;
- that a command dropped during a stall leaves the new parameters staged for the next command;
- the exact range boundaries.

// File: rtl/dma_fe_pkg.sv
package dma_fe_pkg;
  typedef enum logic [2:0] {
    CH_LSA   = 3'd0,
    CH_EAH   = 3'd1,
    CH_EAL   = 3'd2,
    CH_SIZE  = 3'd3,
    CH_TAG   = 3'd4,
    CH_CMD   = 3'd5,
    CH_TMASK = 3'd6,
    CH_TUPD  = 3'd7
  } chan_e;

  typedef enum logic [1:0] {
    CLS_XFER = 2'd0,
    CLS_LIST = 2'd1,
    CLS_ATOM = 2'd2,
    CLS_SYNC = 2'd3
  } cls_e;

  localparam logic [7:0] OP_ATOM_GETLINE = 8'h80;
  localparam logic [7:0] OP_ATOM_PUTCOND = 8'h84;
  localparam logic [7:0] OP_ATOM_PUTUNC  = 8'h88;
  localparam logic [7:0] OP_SYNC_BAR     = 8'hC0;
  localparam logic [7:0] OP_SYNC_ORD     = 8'hC8;
  localparam logic [7:0] OP_SYNC_FULL    = 8'hCC;
endpackage

// File: rtl/dma_fe_stage.sv
module dma_fe_stage
  import dma_fe_pkg::*;
#(
  parameter int LS_AW    = 18,
  parameter int MAX_XFER = 16384,
  parameter int TAGS     = 32,
  localparam int SZW     = $clog2(MAX_XFER + 1),
  localparam int TW      = $clog2(TAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_ch,
  input  logic [31:0]      wr_data,
  input  logic             clr,
  output logic [LS_AW-1:0] lsa,
  output logic [31:0]      eah,
  output logic [31:0]      eal,
  output logic [SZW-1:0]   size,
  output logic [TW-1:0]    tag,
  output logic             bad
);
  localparam logic [31:0] LS_LIMIT  = 32'(1) << LS_AW;
  localparam logic [31:0] SZ_LIMIT  = 32'(MAX_XFER);
  localparam logic [31:0] TAG_LIMIT = 32'(TAGS);

  logic ok_lsa, ok_size, ok_tag;
  logic [LS_AW-1:0] lsa_n;
  logic [31:0]      eah_n, eal_n;
  logic [SZW-1:0]   size_n;
  logic [TW-1:0]    tag_n;

  always_comb begin
    ok_lsa  = wr_data <  LS_LIMIT;
    ok_size = wr_data <= SZ_LIMIT;
    ok_tag  = wr_data <  TAG_LIMIT;
    bad = wr_en && (((wr_ch == CH_LSA)  && !ok_lsa)  ||
                    ((wr_ch == CH_SIZE) && !ok_size) ||
                    ((wr_ch == CH_TAG)  && !ok_tag));
  end

  always_comb begin
    lsa_n  = lsa;
    eah_n  = eah;
    eal_n  = eal;
    size_n = size;
    tag_n  = tag;
    if (clr) begin
      lsa_n  = '0;
      eah_n  = '0;
      eal_n  = '0;
      size_n = '0;
      tag_n  = '0;
    end else if (wr_en) begin
      case (wr_ch)
        CH_LSA:  if (ok_lsa)  lsa_n  = wr_data[LS_AW-1:0];
        CH_EAH:  eah_n = wr_data;
        CH_EAL:  eal_n = wr_data;
        CH_SIZE: if (ok_size) size_n = wr_data[SZW-1:0];
        CH_TAG:  if (ok_tag)  tag_n  = wr_data[TW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsa  <= '0;
      eah  <= '0;
      eal  <= '0;
      size <= '0;
      tag  <= '0;
    end else begin
      lsa  <= lsa_n;
      eah  <= eah_n;
      eal  <= eal_n;
      size <= size_n;
      tag  <= tag_n;
    end
  end
endmodule

// File: rtl/dma_fe_decode.sv
module dma_fe_decode
  import dma_fe_pkg::*;
#(
  parameter int SZW        = 15,
  parameter int LINE_BYTES = 128
) (
  input  logic [7:0]     code,
  input  logic [SZW-1:0] size,
  output logic           legal,
  output logic [1:0]     cls
);
  logic is_xfer, is_atom, is_sync;

  always_comb begin
    is_xfer = ((code[7:4] == 4'h2) || (code[7:4] == 4'h3) || (code[7:4] == 4'h4)) &&
              !code[3] && (code[1:0] != 2'b11);
    is_atom = (code == OP_ATOM_GETLINE) || (code == OP_ATOM_PUTCOND) ||
              (code == OP_ATOM_PUTUNC);
    is_sync = (code == OP_SYNC_BAR) || (code == OP_SYNC_ORD) || (code == OP_SYNC_FULL);
    legal   = 1'b0;
    cls     = CLS_XFER;
    if (is_xfer) begin
      legal = 1'b1;
      cls   = code[2] ? CLS_LIST : CLS_XFER;
    end else if (is_atom) begin
      legal = (size == SZW'(LINE_BYTES));
      cls   = CLS_ATOM;
    end else if (is_sync) begin
      legal = 1'b1;
      cls   = CLS_SYNC;
    end
  end
endmodule

// File: rtl/dma_fe_issue.sv
module dma_fe_issue #(
  parameter int LS_AW = 18,
  parameter int SZW   = 15,
  parameter int TW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       code,
  input  logic             legal,
  input  logic [1:0]       cls,
  input  logic [LS_AW-1:0] lsa,
  input  logic [63:0]      ea,
  input  logic [SZW-1:0]   size,
  input  logic [TW-1:0]    tag,
  input  logic             bad_param,
  input  logic             err_clr,
  input  logic             req_ready,
  output logic             stall,
  output logic             cmd_take,
  output logic             err_flag,
  output logic             req_valid,
  output logic [1:0]       req_class,
  output logic [7:0]       req_code,
  output logic [LS_AW-1:0] req_lsa,
  output logic [63:0]      req_ea,
  output logic [SZW-1:0]   req_size,
  output logic [TW-1:0]    req_tag
);
  logic go, valid_n, err_n;

  always_comb begin
    stall    = req_valid && !req_ready;
    cmd_take = cmd_wr && !stall;
    go       = cmd_take && legal;
    valid_n  = go || stall;
    if (bad_param || (cmd_take && !legal)) err_n = 1'b1;
    else if (err_clr)                      err_n = 1'b0;
    else                                   err_n = err_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      req_valid <= valid_n;
      err_flag  <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_class <= '0;
      req_code  <= '0;
      req_lsa   <= '0;
      req_ea    <= '0;
      req_size  <= '0;
      req_tag   <= '0;
    end else if (go) begin
      req_class <= cls;
      req_code  <= code;
      req_lsa   <= lsa;
      req_ea    <= ea;
      req_size  <= size;
      req_tag   <= tag;
    end
  end
endmodule

// File: rtl/dma_fe_tag.sv
module dma_fe_tag
  import dma_fe_pkg::*;
#(
  parameter int TAGS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_ch,
  input  logic [TAGS-1:0] wr_bits,
  output logic [TAGS-1:0] tag_mask,
  output logic [TAGS-1:0] tag_stat
);
  logic mask_we, stat_we;

  always_comb begin
    mask_we = wr_en && (wr_ch == CH_TMASK);
    stat_we = wr_en && (wr_ch == CH_TUPD);
  end

  for (genvar g = 0; g < TAGS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_mask[g] <= 1'b0;
        tag_stat[g] <= 1'b0;
      end else begin
        if (mask_we) tag_mask[g] <= wr_bits[g];
        if (stat_we) tag_stat[g] <= tag_mask[g];
      end
    end
  end
endmodule

// File: rtl/dma_cmd_front.sv
module dma_cmd_front
  import dma_fe_pkg::*;
#(
  parameter int LS_AW      = 18,
  parameter int MAX_XFER   = 16384,
  parameter int TAGS       = 32,
  parameter int LINE_BYTES = 128,
  localparam int SZW       = $clog2(MAX_XFER + 1),
  localparam int TW        = $clog2(TAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_ch,
  input  logic [31:0]      wr_data,
  output logic             cmd_stall,
  input  logic             err_clr,
  output logic             err_flag,
  output logic [TAGS-1:0]  tag_mask,
  output logic [TAGS-1:0]  tag_stat,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [1:0]       req_class,
  output logic [7:0]       req_code,
  output logic [LS_AW-1:0] req_lsa,
  output logic [63:0]      req_ea,
  output logic [SZW-1:0]   req_size,
  output logic [TW-1:0]    req_tag
);
  logic [LS_AW-1:0] stg_lsa;
  logic [31:0]      stg_eah, stg_eal;
  logic [SZW-1:0]   stg_size;
  logic [TW-1:0]    stg_tag;
  logic             bad_param, cmd_wr, cmd_take, legal;
  logic [1:0]       cls;

  assign cmd_wr = wr_en && (wr_ch == CH_CMD);

  dma_fe_stage #(.LS_AW(LS_AW), .MAX_XFER(MAX_XFER), .TAGS(TAGS)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .clr(cmd_take), .lsa(stg_lsa), .eah(stg_eah), .eal(stg_eal),
    .size(stg_size), .tag(stg_tag), .bad(bad_param)
  );

  dma_fe_decode #(.SZW(SZW), .LINE_BYTES(LINE_BYTES)) u_dec (
    .code(wr_data[7:0]), .size(stg_size), .legal(legal), .cls(cls)
  );

  dma_fe_issue #(.LS_AW(LS_AW), .SZW(SZW), .TW(TW)) u_issue (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .code(wr_data[7:0]),
    .legal(legal), .cls(cls), .lsa(stg_lsa), .ea({stg_eah, stg_eal}),
    .size(stg_size), .tag(stg_tag), .bad_param(bad_param), .err_clr(err_clr),
    .req_ready(req_ready), .stall(cmd_stall), .cmd_take(cmd_take),
    .err_flag(err_flag), .req_valid(req_valid), .req_class(req_class),
    .req_code(req_code), .req_lsa(req_lsa), .req_ea(req_ea),
    .req_size(req_size), .req_tag(req_tag)
  );

  dma_fe_tag #(.TAGS(TAGS)) u_tag (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_bits(wr_data[TAGS-1:0]), .tag_mask(tag_mask), .tag_stat(tag_stat)
  );
endmodule

// File: rtl/dma_cmd_front_chk.sv
module dma_cmd_front_chk #(
  parameter int LS_AW      = 18,
  parameter int MAX_XFER   = 16384,
  parameter int TAGS       = 32,
  parameter int LINE_BYTES = 128,
  localparam int SZW       = $clog2(MAX_XFER + 1),
  localparam int TW        = $clog2(TAGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_ch,
  input logic [31:0]      wr_data,
  input logic             cmd_stall,
  input logic             err_clr,
  input logic             err_flag,
  input logic [TAGS-1:0]  tag_mask,
  input logic [TAGS-1:0]  tag_stat,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_class,
  input logic [7:0]       req_code,
  input logic [63:0]      req_ea,
  input logic [SZW-1:0]   req_size,
  input logic [LS_AW-1:0] stg_lsa,
  input logic [SZW-1:0]   stg_size,
  input logic [TW-1:0]    stg_tag
);
  localparam logic [31:0] LS_LIMIT = 32'(1) << LS_AW;

  a_r2_lsa_reject: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_ch == 3'd0 && wr_data >= LS_LIMIT |=> stg_lsa == $past(stg_lsa) && err_flag);
  a_r3_size_reject: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_ch == 3'd3 && wr_data > 32'(MAX_XFER) |=> stg_size == $past(stg_size) && err_flag);
  a_r4_tag_reject: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_ch == 3'd4 && wr_data >= 32'(TAGS) |=> stg_tag == $past(stg_tag) && err_flag);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_ch == 3'd5 && !cmd_stall |=> stg_lsa == '0 && stg_size == '0 && stg_tag == '0);
  a_r8_atom_line: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_class == 2'd2 |-> req_size == SZW'(LINE_BYTES));
  a_r9_sync_code: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_class == 2'd3 |-> (req_code == 8'hC0 || req_code == 8'hC8 || req_code == 8'hCC));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_ea) && $stable(req_code) && $stable(req_size));
  a_r10_stall_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stall |-> req_valid);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);
  a_r12_tag_update: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_ch == 3'd7 |=> tag_stat == $past(tag_mask));
endmodule

bind dma_cmd_front dma_cmd_front_chk #(
  .LS_AW(LS_AW), .MAX_XFER(MAX_XFER), .TAGS(TAGS), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
  .cmd_stall(cmd_stall), .err_clr(err_clr), .err_flag(err_flag),
  .tag_mask(tag_mask), .tag_stat(tag_stat), .req_valid(req_valid),
  .req_ready(req_ready), .req_class(req_class), .req_code(req_code),
  .req_ea(req_ea), .req_size(req_size), .stg_lsa(stg_lsa),
  .stg_size(stg_size), .stg_tag(stg_tag)
);

// File: tb/dma_cmd_front_tb.sv
`timescale 1ns/1ps
module dma_cmd_front_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, err_clr, req_ready;
  logic [2:0]  wr_ch;
  logic [31:0] wr_data;
  logic        cmd_stall, err_flag, req_valid;
  logic [31:0] tag_mask, tag_stat;
  logic [1:0]  req_class;
  logic [7:0]  req_code;
  logic [17:0] req_lsa;
  logic [63:0] req_ea;
  logic [14:0] req_size;
  logic [4:0]  req_tag;

  int total = 0;
  int bad = 0;

  logic [17:0] m_lsa;
  logic [31:0] m_eah, m_eal, m_mask, m_stat;
  logic [14:0] m_size;
  logic [4:0]  m_tag;
  logic        m_err;

  always #2 clk = ~clk;

  dma_cmd_front u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .cmd_stall(cmd_stall), .err_clr(err_clr), .err_flag(err_flag),
    .tag_mask(tag_mask), .tag_stat(tag_stat), .req_valid(req_valid),
    .req_ready(req_ready), .req_class(req_class), .req_code(req_code),
    .req_lsa(req_lsa), .req_ea(req_ea), .req_size(req_size), .req_tag(req_tag)
  );

  task automatic chk(input string name, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", name, act, exp);
    end
  endtask

  // {legal, class}
  function automatic logic [2:0] ref_dec(input logic [7:0] c, input logic [14:0] sz);
    if ((c[7:4] == 4'h2 || c[7:4] == 4'h3 || c[7:4] == 4'h4) && !c[3] && c[1:0] != 2'b11)
      return {1'b1, 1'b0, c[2]};
    if (c == 8'h80 || c == 8'h84 || c == 8'h88)
      return (sz == 15'd128) ? 3'b110 : 3'b010;
    if (c == 8'hC0 || c == 8'hC8 || c == 8'hCC)
      return 3'b111;
    return 3'b000;
  endfunction

  function automatic string ch_req(input logic [2:0] ch);
    case (ch)
      3'd0: return "R2";
      3'd1, 3'd2: return "R5";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R6";
      default: return "R12";
    endcase
  endfunction

  // raw drive at a falling edge; returns at the next falling edge
  task automatic drive(input logic [2:0] ch, input logic [31:0] d, input logic clr);
    wr_en = 1'b1; wr_ch = ch; wr_data = d; err_clr = clr;
    @(negedge clk);
    wr_en = 1'b0; err_clr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] ch, input logic [31:0] d);
    logic [2:0]  dec = 3'b000;
    logic        exp_bad = 1'b0;
    logic [17:0] e_lsa = m_lsa;
    logic [63:0] e_ea = {m_eah, m_eal};
    logic [14:0] e_size = m_size;
    logic [4:0]  e_tag = m_tag;
    string       rq = ch_req(ch);
    case (ch)
      3'd0: if (d < 32'h40000) m_lsa = d[17:0]; else exp_bad = 1'b1;
      3'd1: m_eah = d;
      3'd2: m_eal = d;
      3'd3: if (d <= 32'd16384) m_size = d[14:0]; else exp_bad = 1'b1;
      3'd4: if (d < 32'd32) m_tag = d[4:0]; else exp_bad = 1'b1;
      3'd5: begin dec = ref_dec(d[7:0], m_size); if (!dec[2]) exp_bad = 1'b1; end
      3'd6: m_mask = d;
      default: m_stat = m_mask;
    endcase
    drive(ch, d, 1'b0);
    if (exp_bad) m_err = 1'b1;
    chk({"R11 err after ", rq}, err_flag, m_err);
    if (ch == 3'd5) begin
      chk("R6 R9 request raised", req_valid, dec[2]);
      if (dec[2]) begin
        chk("R7 R8 R9 class", req_class, dec[1:0]);
        chk("R6 code", req_code, d[7:0]);
        chk("R6 lsa", req_lsa, e_lsa);
        chk("R5 ea", req_ea, e_ea);
        chk("R6 size", req_size, e_size);
        chk("R6 tag", req_tag, e_tag);
      end
      m_lsa = '0; m_eah = '0; m_eal = '0; m_size = '0; m_tag = '0;
    end else if (req_ready) begin
      chk({"R6 no request on ", rq}, req_valid, 1'b0);
    end
    if (ch >= 3'd6) begin
      chk("R12 tag_mask", tag_mask, m_mask);
      chk("R12 tag_stat", tag_stat, m_stat);
    end
  endtask

  task automatic clear_err(input logic also_bad_tag);
    if (also_bad_tag) drive(3'd4, 32'd40, 1'b1);
    else begin err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; end
    m_err = also_bad_tag;
    chk("R11 clear / set wins", err_flag, m_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] codes [22] = '{8'h20, 8'h21, 8'h22, 8'h24, 8'h25, 8'h26, 8'h30, 8'h31,
                               8'h32, 8'h34, 8'h40, 8'h41, 8'h42, 8'h44, 8'h45, 8'h46,
                               8'h80, 8'h84, 8'h88, 8'hC0, 8'hC8, 8'hCC};
    void'($urandom(32'h1d5e));
    rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_data = '0; err_clr = 1'b0; req_ready = 1'b1;
    m_lsa = '0; m_eah = '0; m_eal = '0; m_size = '0; m_tag = '0; m_err = 1'b0;
    m_mask = '0; m_stat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 req_valid", req_valid, 1'b0);
    chk("R1 cmd_stall", cmd_stall, 1'b0);
    chk("R1 err_flag", err_flag, 1'b0);
    chk("R1 tag_mask", tag_mask, 0);
    chk("R1 tag_stat", tag_stat, 0);
    wr(3'd5, 32'h20);  // R1: staged arguments are zero

    // R5 / R2 / R3 / R4 boundaries accepted, R7 list
    wr(3'd1, 32'hDEADBEEF);
    wr(3'd2, 32'h01234567);
    wr(3'd0, 32'h3FFFF);
    wr(3'd3, 32'd16384);
    wr(3'd4, 32'd31);
    wr(3'd5, 32'h24);
    wr(3'd5, 32'h40);  // R6 arguments cleared

    // rejects keep old value
    wr(3'd0, 32'h100); wr(3'd0, 32'h40000);
    wr(3'd3, 32'd200); wr(3'd3, 32'd16385);
    wr(3'd4, 32'd9);   wr(3'd4, 32'd32);
    wr(3'd5, 32'h31);
    clear_err(1'b0);
    clear_err(1'b1);
    clear_err(1'b0);

    // R8 atomic size rule
    wr(3'd3, 32'd128); wr(3'd5, 32'h84);
    wr(3'd3, 32'd127); wr(3'd5, 32'h80);
    clear_err(1'b0);
    // R9 barrier and illegal codes
    wr(3'd5, 32'hCC);
    wr(3'd5, 32'h50);
    wr(3'd5, 32'h23);
    clear_err(1'b0);

    // R12 tag mask / update
    wr(3'd6, 32'hA5A50F0F);
    wr(3'd7, 32'h0);
    wr(3'd6, 32'h00000011);

    // R10 stall
    req_ready = 1'b0;
    wr(3'd0, 32'h40); wr(3'd3, 32'd64); wr(3'd4, 32'd3);
    wr(3'd5, 32'h20);
    chk("R10 stall raised", cmd_stall, 1'b1);
    wr(3'd0, 32'h80); wr(3'd3, 32'd256); wr(3'd4, 32'd7);
    drive(3'd5, 32'h40, 1'b0);  // dropped
    chk("R10 held valid", req_valid, 1'b1);
    chk("R10 held code", req_code, 8'h20);
    chk("R10 held lsa", req_lsa, 18'h40);
    chk("R10 held size", req_size, 15'd64);
    chk("R10 stall still", cmd_stall, 1'b1);
    req_ready = 1'b1;
    @(negedge clk);
    chk("R10 accepted", req_valid, 1'b0);
    chk("R10 stall released", cmd_stall, 1'b0);
    wr(3'd5, 32'h30);  // staged args survive the dropped command

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  ch = 3'($urandom % 8);
      logic [31:0] d = $urandom;
      case (ch)
        3'd0: d = ($urandom % 4 == 0) ? 32'h40000 + ($urandom % 16) : $urandom % 32'h40000;
        3'd3: case ($urandom % 3)
                0: d = 32'd128;
                1: d = $urandom % 16385;
                default: d = 32'd16380 + ($urandom % 10);
              endcase
        3'd4: d = $urandom % 36;
        3'd5: d = ($urandom % 5 == 0) ? ($urandom % 256) : 32'(codes[$urandom % 22]);
        default: ;
      endcase
      wr(ch, d);
      if ($urandom % 12 == 0) clear_err(1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule